// File: doc/BRIEF.md
# YUV Superframe Line Formatter

This block builds the lines of a "superframe" video stream and sends them out one byte at a time. Each output line has two halves. The first half is the current frame's processed colour pixels in 4:2:2 form: one chroma pair for every two pixels, interleaved with the luma values. The second half is the raw 14-bit samples for the same line, which come from the previous frame. Each raw sample is widened to 16 bits and sent as two bytes. A line of 320 pixels is therefore 1280 bytes long.

The block reads the colour pixels a pair at a time through an addressed port. It drives `pair_idx`, and the source returns the Y, Cb and Cr values of the even and odd pixel of that pair in the same cycle. Raw samples for the next line are written in order into a ping-pong line buffer. The buffer swaps banks at the start of each line.

Frame timing is produced by a state machine:
- `ST_VBLANK`: vertical blank, frame sync low.
- `ST_FPORCH`: one-cycle front porch, frame sync high.
- `ST_ACTIVE`: line sync high while the bytes are sent.
- `ST_HBLANK`: gap between lines.
- `ST_BPORCH`: one-cycle back porch after the last line of the frame.

The transitions are:
- vblank-done: `ST_VBLANK` to `ST_FPORCH`.
- frame-open: `ST_FPORCH` to `ST_ACTIVE`. This transition swaps the line-buffer banks.
- line-gap: `ST_ACTIVE` to `ST_HBLANK`, after a line that is not the last of the frame.
- line-open: `ST_HBLANK` to `ST_ACTIVE`. This transition also swaps the banks.
- frame-close: `ST_ACTIVE` to `ST_BPORCH`, after the last line of the frame.
- blank-enter: `ST_BPORCH` to `ST_VBLANK`.

The block advances by one step only in cycles where `en` is high.

Top module: `yuvsf_line_formatter`

## Requirements
- R1: While reset is held and after it is released, before any enabled cycle, `vid_data`, `vid_lsync` and `vid_fsync` are all zero.
- R2: Line sync stays high for exactly 4×PIXELS enabled output cycles per line (1280 by default). A frame holds LINES_PER_FRAME lines (240 by default).
- R3: In the colour half, byte k of the line is sent in the following order:
  - k mod 4 = 0: the pair's Cb.
  - k mod 4 = 1: the even pixel's Y.
  - k mod 4 = 2: the pair's Cr.
  - k mod 4 = 3: the odd pixel's Y.
  
  Here pair k/4 covers pixels 2·(k/4) and 2·(k/4)+1, counted from 0.
- R4: Each chroma byte is (even + odd) >> 1, computed on a 9-bit sum. Cb and Cr are computed separately, so 255 and 255 give 255, and 255 and 0 give 127.
- R5: The raw half starts at byte 2×PIXELS and carries the samples in order, two bytes per sample. The first byte is sample bits 7:0. The second byte is {2'b00, sample bits 13:8}, because each sample is zero-extended to 16 bits.
- R6: Each byte appears on `vid_data[13:6]` with its MSB on bit 13. `vid_data[5:0]` is always zero.
- R7: Frame sync rises one enabled cycle before the first line sync of a frame. It falls one enabled cycle after the last line sync ends, and stays low for FRAME_BLANK enabled cycles. Lines within a frame are separated by LINE_BLANK enabled cycles with line sync low. Line sync is high only while frame sync is high.
- R8: The raw half of a line carries the first PIXELS samples written to the buffer since the previous line started. Writes beyond PIXELS in one line period are ignored.
- R9: In a cycle where `en` is low, no output and no internal position changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Advance enable, one byte per high cycle |
| pair_idx | output | 8 | Index of the pixel pair being read |
| y_even | input | 8 | Luma of pixel 2·pair_idx |
| y_odd | input | 8 | Luma of pixel 2·pair_idx+1 |
| cb_even | input | 8 | Cb of the even pixel |
| cb_odd | input | 8 | Cb of the odd pixel |
| cr_even | input | 8 | Cr of the even pixel |
| cr_odd | input | 8 | Cr of the odd pixel |
| raw_wr_en | input | 1 | Write one raw sample for the next line |
| raw_wr_data | input | 14 | Raw sample |
| vid_data | output | 14 | Output bus, byte on bits 13:6 |
| vid_lsync | output | 1 | Line sync |
| vid_fsync | output | 1 | Frame sync |

## Verification
The assertions assume the following about the inputs:
- The pixel source answers `pair_idx` combinationally, in the same cycle.
- Each line's raw samples reach the buffer before the bank swap that opens that line.
- No raw write falls on a swap cycle.
- Both blanking lengths are at least one.

The bench writes line 0's raw samples while `en` is still low. It writes each later line only after the previous line's sync has risen, and finishes within 330 cycles, well inside a 1280-byte line. It toggles `en` at random, so the sync and porch properties are exercised under stalls. It draws the pixel values at random, with directed extremes at the start of the first line.

// File: rtl/yuvsf_pkg.sv
package yuvsf_pkg;

    typedef enum logic [2:0] {
        ST_VBLANK,
        ST_FPORCH,
        ST_ACTIVE,
        ST_HBLANK,
        ST_BPORCH
    } yuvsf_state_e;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/yuvsf_pair_avg.sv
module yuvsf_pair_avg #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] avg
);

    logic [W:0] sum;

    always_comb begin
        sum = {1'b0, a} + {1'b0, b};
        avg = sum[W:1];
        // R4
        avg_bound_chk: assert ((avg >= ((a < b) ? a : b)) && (avg <= ((a > b) ? a : b)))
            else $error("average outside its operands");
    end

endmodule

// File: rtl/yuvsf_raw_pingpong.sv
module yuvsf_raw_pingpong #(
    parameter int DEPTH = 320,
    parameter int W     = 14
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     swap,
    input  logic                     wr_en,
    input  logic [W-1:0]             wr_data,
    input  logic [$clog2(DEPTH)-1:0] rd_idx,
    output logic [W-1:0]             rd_data
);

    localparam int AW = $clog2(DEPTH);
    localparam int PW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [2][DEPTH];
    logic          fill_q;
    logic [PW-1:0] wptr_q;
    logic          wbank;
    logic [AW-1:0] waddr;
    logic          wr_go;

    always_comb begin
        wbank = swap ? ~fill_q : fill_q;
        waddr = swap ? '0 : wptr_q[AW-1:0];
        wr_go = wr_en && (swap || (wptr_q < PW'(DEPTH)));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_q <= 1'b0;
            wptr_q <= '0;
        end else begin
            if (swap) begin
                fill_q <= ~fill_q;
                wptr_q <= wr_en ? PW'(1) : '0;
            end else if (wr_go) begin
                wptr_q <= wptr_q + PW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wr_go) begin
            mem[wbank][waddr] <= wr_data;
        end
    end

    always_comb begin
        if (rd_idx < AW'(DEPTH)) begin
            rd_data = mem[~fill_q][rd_idx];
        end else begin
            rd_data = '0;
        end
    end

    // R8
    wptr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wptr_q <= PW'(DEPTH))
        else $error("write pointer past line depth");

endmodule

// File: rtl/yuvsf_timing_fsm.sv
module yuvsf_timing_fsm
    import yuvsf_pkg::*;
#(
    parameter int LINE_BYTES      = 1280,
    parameter int LINES_PER_FRAME = 240,
    parameter int LINE_BLANK      = 16,
    parameter int FRAME_BLANK     = 64
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          en,
    output yuvsf_state_e                  state_o,
    output logic [$clog2(LINE_BYTES)-1:0] bcnt_o,
    output logic                          swap_o
);

    localparam int BW    = $clog2(LINE_BYTES);
    localparam int BMAX  = (FRAME_BLANK > LINE_BLANK) ? FRAME_BLANK : LINE_BLANK;
    localparam int CW    = $clog2(BMAX + 1);
    localparam int LW    = $clog2(LINES_PER_FRAME + 1);
    localparam logic [BW-1:0] LAST_BYTE = BW'(LINE_BYTES - 1);
    localparam logic [CW-1:0] FB_LAST   = CW'(FRAME_BLANK - 1);
    localparam logic [CW-1:0] LB_LAST   = CW'(LINE_BLANK - 1);
    localparam logic [LW-1:0] LAST_LINE = LW'(LINES_PER_FRAME - 1);

    yuvsf_state_e  state_q, state_n;
    logic [BW-1:0] bcnt_q, bcnt_n;
    logic [CW-1:0] cnt_q, cnt_n;
    logic [LW-1:0] line_q, line_n;
    logic          swap_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_VBLANK;
            bcnt_q  <= '0;
            cnt_q   <= '0;
            line_q  <= '0;
        end else if (en) begin
            state_q <= state_n;
            bcnt_q  <= bcnt_n;
            cnt_q   <= cnt_n;
            line_q  <= line_n;
        end
    end

    always_comb begin
        state_n = state_q;
        bcnt_n  = bcnt_q;
        cnt_n   = cnt_q;
        line_n  = line_q;
        swap_n  = 1'b0;
        unique case (state_q)
            ST_VBLANK: begin
                if (cnt_q == FB_LAST) begin
                    state_n = ST_FPORCH;
                    cnt_n   = '0;
                end else begin
                    cnt_n = cnt_q + CW'(1);
                end
            end
            ST_FPORCH: begin
                state_n = ST_ACTIVE;
                bcnt_n  = '0;
                line_n  = '0;
                swap_n  = 1'b1;
            end
            ST_ACTIVE: begin
                if (bcnt_q == LAST_BYTE) begin
                    cnt_n = '0;
                    if (line_q == LAST_LINE) begin
                        state_n = ST_BPORCH;
                    end else begin
                        state_n = ST_HBLANK;
                    end
                end else begin
                    bcnt_n = bcnt_q + BW'(1);
                end
            end
            ST_HBLANK: begin
                if (cnt_q == LB_LAST) begin
                    state_n = ST_ACTIVE;
                    bcnt_n  = '0;
                    line_n  = line_q + LW'(1);
                    swap_n  = 1'b1;
                end else begin
                    cnt_n = cnt_q + CW'(1);
                end
            end
            ST_BPORCH: begin
                state_n = ST_VBLANK;
                cnt_n   = '0;
            end
            default: begin
                state_n = ST_VBLANK;
            end
        endcase
    end

    assign state_o = state_q;
    assign bcnt_o  = bcnt_q;
    assign swap_o  = swap_n && en;

    // R9
    state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(state_q) && $stable(bcnt_q))
        else $error("sequencer moved while stalled");

    // R2
    line_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_q <= LAST_LINE)
        else $error("line index past frame height");

endmodule

// File: rtl/yuvsf_line_formatter.sv
module yuvsf_line_formatter
    import yuvsf_pkg::*;
#(
    parameter int PIXELS          = 320,
    parameter int RAW_W           = 14,
    parameter int BUS_W           = 14,
    parameter int LANE_LSB        = 6,
    parameter int LINES_PER_FRAME = 240,
    parameter int LINE_BLANK      = 16,
    parameter int FRAME_BLANK     = 64
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            en,
    output logic [$clog2(PIXELS/2)-1:0]     pair_idx,
    input  logic [7:0]                      y_even,
    input  logic [7:0]                      y_odd,
    input  logic [7:0]                      cb_even,
    input  logic [7:0]                      cb_odd,
    input  logic [7:0]                      cr_even,
    input  logic [7:0]                      cr_odd,
    input  logic                            raw_wr_en,
    input  logic [RAW_W-1:0]                raw_wr_data,
    output logic [BUS_W-1:0]                vid_data,
    output logic                            vid_lsync,
    output logic                            vid_fsync
);

    localparam int COLOR_BYTES = 2 * PIXELS;
    localparam int LINE_BYTES  = 4 * PIXELS;
    localparam int BW          = $clog2(LINE_BYTES);
    localparam int PAIR_W      = $clog2(PIXELS / 2);
    localparam int IDX_W       = $clog2(PIXELS);

    yuvsf_state_e      state;
    logic [BW-1:0]     bcnt;
    logic [BW-1:0]     roff;
    logic              swap;
    logic [IDX_W-1:0]  raw_idx;
    logic [RAW_W-1:0]  raw_rd;
    logic [15:0]       raw16;
    logic [BYTE_W-1:0] byte_sel;
    logic [BYTE_W-1:0] ch_a   [2];
    logic [BYTE_W-1:0] ch_b   [2];
    logic [BYTE_W-1:0] ch_avg [2];

    yuvsf_timing_fsm #(
        .LINE_BYTES      (LINE_BYTES),
        .LINES_PER_FRAME (LINES_PER_FRAME),
        .LINE_BLANK      (LINE_BLANK),
        .FRAME_BLANK     (FRAME_BLANK)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .state_o (state),
        .bcnt_o  (bcnt),
        .swap_o  (swap)
    );

    assign ch_a[0] = cb_even;
    assign ch_b[0] = cb_odd;
    assign ch_a[1] = cr_even;
    assign ch_b[1] = cr_odd;

    for (genvar c = 0; c < 2; c++) begin : g_chroma
        yuvsf_pair_avg #(.W(BYTE_W)) u_avg (
            .a   (ch_a[c]),
            .b   (ch_b[c]),
            .avg (ch_avg[c])
        );
    end

    always_comb begin
        roff     = bcnt - BW'(COLOR_BYTES);
        raw_idx  = roff[IDX_W:1];
        pair_idx = bcnt[PAIR_W+1:2];
    end

    yuvsf_raw_pingpong #(
        .DEPTH (PIXELS),
        .W     (RAW_W)
    ) u_raw (
        .clk     (clk),
        .rst_n   (rst_n),
        .swap    (swap),
        .wr_en   (raw_wr_en),
        .wr_data (raw_wr_data),
        .rd_idx  (raw_idx),
        .rd_data (raw_rd)
    );

    always_comb begin
        raw16 = 16'(raw_rd);
        if (bcnt < BW'(COLOR_BYTES)) begin
            unique case (bcnt[1:0])
                2'd0:    byte_sel = ch_avg[0];
                2'd1:    byte_sel = y_even;
                2'd2:    byte_sel = ch_avg[1];
                default: byte_sel = y_odd;
            endcase
        end else begin
            byte_sel = roff[0] ? raw16[15:8] : raw16[7:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vid_data  <= '0;
            vid_lsync <= 1'b0;
            vid_fsync <= 1'b0;
        end else if (en) begin
            vid_lsync <= (state == ST_ACTIVE);
            vid_fsync <= (state != ST_VBLANK);
            vid_data  <= (state == ST_ACTIVE) ? (BUS_W'(byte_sel) << LANE_LSB) : '0;
        end
    end

    // R7
    fporch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vid_lsync) |-> $past(vid_fsync))
        else $error("line opened without front porch");

    // R7
    bporch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vid_fsync) |-> !$past(vid_lsync))
        else $error("frame closed without back porch");

    // R7
    lsync_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vid_lsync |-> vid_fsync)
        else $error("line sync outside frame");

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(vid_data) && $stable(vid_lsync) && $stable(vid_fsync))
        else $error("outputs moved while stalled");

endmodule

// File: tb/tb_yuvsf_line_formatter.sv
module tb_yuvsf_line_formatter;

    localparam int PIX    = 320;
    localparam int NL     = 6;
    localparam int LPF    = 3;
    localparam int FB     = 20;
    localparam int LB     = 8;
    localparam int LBYTES = 4 * PIX;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        en;
    logic [7:0]  pair_idx;
    logic [7:0]  y_even, y_odd, cb_even, cb_odd, cr_even, cr_odd;
    logic        raw_wr_en;
    logic [13:0] raw_wr_data;
    logic [13:0] vid_data;
    logic        vid_lsync, vid_fsync;

    always #5 clk = ~clk;

    yuvsf_line_formatter #(
        .LINES_PER_FRAME (LPF),
        .LINE_BLANK      (LB),
        .FRAME_BLANK     (FB)
    ) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en),
        .pair_idx    (pair_idx),
        .y_even      (y_even),
        .y_odd       (y_odd),
        .cb_even     (cb_even),
        .cb_odd      (cb_odd),
        .cr_even     (cr_even),
        .cr_odd      (cr_odd),
        .raw_wr_en   (raw_wr_en),
        .raw_wr_data (raw_wr_data),
        .vid_data    (vid_data),
        .vid_lsync   (vid_lsync),
        .vid_fsync   (vid_fsync)
    );

    logic [7:0]  py  [NL][PIX];
    logic [7:0]  pcb [NL][PIX];
    logic [7:0]  pcr [NL][PIX];
    logic [13:0] praw[NL][PIX];

    int checks = 0;
    int fails  = 0;
    int lseed  = 0;
    bit done   = 1'b0;
    bit mon_on = 1'b0;
    logic en_s = 1'b0;

    int pe;
    always_comb begin
        pe = (int'(pair_idx) < PIX / 2) ? 2 * int'(pair_idx) : 0;
        y_even  = py [lseed][pe];
        y_odd   = py [lseed][pe+1];
        cb_even = pcb[lseed][pe];
        cb_odd  = pcb[lseed][pe+1];
        cr_even = pcr[lseed][pe];
        cr_odd  = pcr[lseed][pe+1];
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mean8(input logic [7:0] a, input logic [7:0] b);
        logic [8:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[8:1];
    endfunction

    function automatic logic [7:0] exp_byte(input int l, input int pos);
        int p, r, i;
        if (pos < 2 * PIX) begin
            p = pos / 4;
            case (pos % 4)
                0:       return mean8(pcb[l][2*p], pcb[l][2*p+1]);
                1:       return py[l][2*p];
                2:       return mean8(pcr[l][2*p], pcr[l][2*p+1]);
                default: return py[l][2*p+1];
            endcase
        end
        r = pos - 2 * PIX;
        i = r / 2;
        if (r % 2 == 0) return praw[l][i][7:0];
        return {2'b00, praw[l][i][13:8]};
    endfunction

    task automatic wr_line(input int l, input int extra);
        for (int i = 0; i < PIX; i++) begin
            @(negedge clk);
            raw_wr_en   = 1'b1;
            raw_wr_data = praw[l][i];
        end
        for (int i = 0; i < extra; i++) begin
            @(negedge clk);
            raw_wr_en   = 1'b1;
            raw_wr_data = 14'h1555;
        end
        @(negedge clk);
        raw_wr_en = 1'b0;
    endtask

    always @(posedge clk) en_s <= en;

    // monitor state
    logic [13:0] prev_d = '0;
    logic        prev_l = 1'b0;
    logic        prev_f = 1'b0;
    bit in_line = 1'b0;
    int pos = 0, line_idx = 0, blank = 0, flow = 0, lif = 0;

    always @(negedge clk) begin
        if (mon_on) begin
            if (!en_s) begin
                // R9: stall holds outputs
                chk(vid_data == prev_d && vid_lsync == prev_l && vid_fsync == prev_f,
                    "R9 stall hold", int'(vid_data), int'(prev_d));
            end else begin
                if (vid_fsync && !prev_f) begin
                    // R7: vertical blank length
                    chk(flow == FB, "R7 vblank length", flow, FB);
                    lif = 0;
                end
                if (!vid_fsync) begin
                    if (prev_f) begin
                        // R2: lines per frame, R7: back porch
                        chk(lif == LPF, "R2 lines per frame", lif, LPF);
                        chk(!prev_l, "R7 back porch", int'(prev_l), 0);
                        flow = 0;
                    end
                    flow++;
                end
                if (vid_lsync) begin
                    if (!in_line) begin
                        in_line = 1'b1;
                        pos = 0;
                        // R7: front porch
                        chk(prev_f && !prev_l, "R7 front porch", int'(prev_f), 1);
                        if (line_idx > 0) begin
                            if (lif > 0) chk(blank == LB, "R7 line gap", blank, LB);
                            else         chk(blank == FB + 2, "R7 frame gap", blank, FB + 2);
                        end
                        lif++;
                    end
                    if (line_idx < NL && pos < LBYTES) begin
                        if (pos == 0)
                            chk(vid_data[5:0] == 6'd0, "R6 low lane zero", int'(vid_data[5:0]), 0);
                        if (pos < 2 * PIX)
                            chk(vid_data[13:6] == exp_byte(line_idx, pos),
                                (pos % 2 == 1) ? "R3 colour order" : "R4 chroma mean",
                                int'(vid_data[13:6]), int'(exp_byte(line_idx, pos)));
                        else
                            chk(vid_data[13:6] == exp_byte(line_idx, pos),
                                (line_idx == 2) ? "R8 overfill ignored" : "R5 raw bytes",
                                int'(vid_data[13:6]), int'(exp_byte(line_idx, pos)));
                    end
                    pos++;
                end else begin
                    if (in_line) begin
                        // R2: line length
                        chk(pos == LBYTES, "R2 line length", pos, LBYTES);
                        in_line = 1'b0;
                        line_idx++;
                        lseed = (line_idx < NL) ? line_idx : NL - 1;
                        blank = 0;
                    end
                    blank++;
                end
            end
            prev_d = vid_data;
            prev_l = vid_lsync;
            prev_f = vid_fsync;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int l = 0; l < NL; l++) begin
            for (int i = 0; i < PIX; i++) begin
                py[l][i]   = 8'($urandom);
                pcb[l][i]  = 8'($urandom);
                pcr[l][i]  = 8'($urandom);
                praw[l][i] = 14'($urandom);
            end
        end
        // directed corners on line 0
        pcb[0][0] = 8'hFF; pcb[0][1] = 8'hFF;
        pcr[0][0] = 8'h00; pcr[0][1] = 8'h00;
        pcb[0][2] = 8'hFF; pcb[0][3] = 8'h00;
        pcr[0][2] = 8'h01; pcr[0][3] = 8'h02;
        py[0][0]  = 8'hFF; py[0][1]  = 8'h00;
        praw[0][0] = 14'h3FFF;
        praw[0][1] = 14'h0000;
        praw[0][PIX-1] = 14'h2A81;

        rst_n = 1'b0; en = 1'b0; raw_wr_en = 1'b0; raw_wr_data = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(vid_data == 14'd0, "R1 reset data", int'(vid_data), 0);
        chk(!vid_lsync, "R1 reset lsync", int'(vid_lsync), 0);
        chk(!vid_fsync, "R1 reset fsync", int'(vid_fsync), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(vid_data == 14'd0 && !vid_lsync && !vid_fsync, "R1 after release",
            int'(vid_data), 0);
        wr_line(0, 0);
        mon_on = 1'b1;
        fork
            begin
                while (!done) begin
                    @(negedge clk);
                    en = ($urandom % 4) != 0;
                end
            end
            begin
                for (int k = 1; k < NL; k++) begin
                    @(posedge vid_lsync);
                    wr_line(k, (k == 2) ? 10 : 0);
                end
            end
        join_none
        wait (line_idx >= NL);
        repeat (20) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", line_idx, NL);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule